// File: doc/BRIEF.md
# DMA Channel Flow-Control Sequencer

This block is the control core of one DMA channel. It decides when a packet transfer may move a data beat, when the packet is over, and what happens once it is over. Writing a configuration word with its enable bit set starts the channel at once. The word selects the transfer direction, the flow controller, the transfer size and the terminal-count interrupt enable. Address generation, bus mastering and the data path sit outside the block. They appear here as a single beat request/beat done handshake.

The flow controller decides the packet length. When the DMA controls the flow, a down-counter loaded from the programmed size ends the packet. When the source or destination peripheral controls it, the size is ignored and the packet ends on that peripheral's last-transfer flag. A finished packet always produces three events in turn: an acknowledge pulse to each peripheral side, then the sticky terminal-count flag (only if enabled), then either a request to load the next linked item or, if there is no next item, a return to idle with the channel disabled.

Top module: `dma_flow_seq`

## Requirements
- R1: After reset the channel is idle and disabled: busy, ch_en, beat_req, src_ack, dst_ack, lli_load, tc_irq and cfg_err are all low.
- R2: A configuration write (cfg_wr) in idle with cfg_en high and a legal code pair raises ch_en and busy on the following cycle, and the channel starts without any further command.
- R3: The flow code cfg_flow means 0 = DMA, 1 = source peripheral, 2 = destination peripheral. Code 0 is legal for every direction. Code 1 is legal only for directions 1 and 3. Code 2 is legal only for directions 0 and 3. Codes 3 to 7 are never legal. An idle write with an illegal pair sets cfg_err and leaves ch_en low. A later legal write clears cfg_err.
- R4: The direction code cfg_dir means 0 = memory-to-peripheral, 1 = peripheral-to-memory, 2 = memory-to-memory and 3 = peripheral-to-peripheral. A beat is requested only when the pacing for that direction allows it: dst_req for 0, src_req for 1, always for 2, and src_req and dst_req together for 3.
- R5: With DMA flow control the packet has exactly cfg_size beats. The 12-bit count drops by one on each beat_done.
- R6: With DMA flow control a size of zero completes the packet with no beat at all.
- R7: With peripheral flow control the size is ignored. The packet ends on the beat where the controlling peripheral's last flag (src_last or dst_last) is high, and the other peripheral's last flag has no effect.
- R8: On completion src_ack (for directions 1 and 3) and dst_ack (for directions 0 and 3) pulse for exactly one cycle. tc_irq rises on the next cycle, and lli_load or the return to idle comes one cycle after that.
- R9: tc_irq is set on completion only when cfg_tc_ie was set in the configuration. It stays set until a tc_clr pulse clears it.
- R10: A zero next_lli at completion clears ch_en and returns the channel to idle. A non-zero next_lli gives a one-cycle lli_load pulse. The channel then waits for lli_reload, reloads the count from cfg_size and runs the next packet with the same settings.
- R11: A write with cfg_en low while a packet is active stops the channel at the next beat boundary, with no acknowledge, no terminal-count flag and no lli_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable bit of the configuration word |
| cfg_dir | input | 2 | Transfer direction code |
| cfg_flow | input | 3 | Flow controller code |
| cfg_size | input | 12 | Transfer size in beats; also read at lli_reload |
| cfg_tc_ie | input | 1 | Terminal-count interrupt enable |
| src_req | input | 1 | Source peripheral request |
| dst_req | input | 1 | Destination peripheral request |
| beat_req | output | 1 | Request to the data path for one beat |
| beat_done | input | 1 | Data path finished the requested beat |
| src_last | input | 1 | Source peripheral marks the last beat, valid with beat_done |
| dst_last | input | 1 | Destination peripheral marks the last beat, valid with beat_done |
| src_ack | output | 1 | Completion acknowledge to the source peripheral |
| dst_ack | output | 1 | Completion acknowledge to the destination peripheral |
| tc_irq | output | 1 | Sticky terminal-count flag |
| tc_clr | input | 1 | Write-one-to-clear for tc_irq |
| next_lli | input | 32 | Address of the next linked item, zero for none |
| lli_load | output | 1 | Request to fetch the next linked item |
| lli_reload | input | 1 | Next linked item is in place, restart |
| ch_en | output | 1 | Channel enable state |
| cfg_err | output | 1 | Last idle configuration write was illegal |
| busy | output | 1 | Channel not idle |

## Verification
The assertions assume that the data path raises beat_done only while beat_req is high, for one cycle at a time. They also assume that src_last and dst_last are read only alongside beat_done. The bench's beat responder keeps to this. It answers a pending beat_req with a single beat_done cycle, and it drives the last flags only during that cycle. The assertions also assume that lli_reload comes only after lli_load and that next_lli is stable around completion. The bench sets next_lli before it starts each packet and pulses lli_reload only once it has seen lli_load.

// File: rtl/dma_flow_seq.sv
module dma_flow_seq #(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_dir,
  input  logic [2:0]        cfg_flow,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic              cfg_tc_ie,
  input  logic              src_req,
  input  logic              dst_req,
  output logic              beat_req,
  input  logic              beat_done,
  input  logic              src_last,
  input  logic              dst_last,
  output logic              src_ack,
  output logic              dst_ack,
  output logic              tc_irq,
  input  logic              tc_clr,
  input  logic [ADDR_W-1:0] next_lli,
  output logic              lli_load,
  input  logic              lli_reload,
  output logic              ch_en,
  output logic              cfg_err,
  output logic              busy
);

  localparam logic [1:0] M2P = 2'd0, P2M = 2'd1, M2M = 2'd2, P2P = 2'd3;
  localparam logic [2:0] FC_DMA = 3'd0, FC_SRC = 3'd1, FC_DST = 3'd2;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_BEAT, S_ACK, S_IRQ, S_NEXT, S_WLOAD} st_t;

  st_t             st;
  logic [1:0]      dir_q;
  logic [2:0]      flow_q;
  logic            ie_q, en_q, err_q, tc_q;
  logic [CNT_W-1:0] cnt;

  function automatic logic legal(input logic [1:0] d, input logic [2:0] f);
    case (f)
      FC_DMA:  return 1'b1;
      FC_SRC:  return (d == P2M) || (d == P2P);
      FC_DST:  return (d == M2P) || (d == P2P);
      default: return 1'b0;
    endcase
  endfunction

  logic src_per, dst_per, pace_ok, stop_wr, en_eff, last_hit;

  assign src_per = (dir_q == P2M) || (dir_q == P2P);
  assign dst_per = (dir_q == M2P) || (dir_q == P2P);
  assign stop_wr = cfg_wr && !cfg_en;
  assign en_eff  = en_q && !stop_wr;

  always_comb begin
    case (dir_q)
      M2P:     pace_ok = dst_req;
      P2M:     pace_ok = src_req;
      M2M:     pace_ok = 1'b1;
      default: pace_ok = src_req && dst_req;
    endcase
    case (flow_q)
      FC_SRC:  last_hit = src_last;
      FC_DST:  last_hit = dst_last;
      default: last_hit = (cnt == CNT_W'(1));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dir_q  <= M2P;
      flow_q <= FC_DMA;
      ie_q   <= 1'b0;
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      tc_q   <= 1'b0;
      cnt    <= '0;
    end else begin
      if (tc_clr) tc_q <= 1'b0;
      if (st == S_ACK && ie_q) tc_q <= 1'b1;
      if (st != S_IDLE && stop_wr) en_q <= 1'b0;
      case (st)
        S_IDLE: if (cfg_wr) begin
          dir_q  <= cfg_dir;
          flow_q <= cfg_flow;
          ie_q   <= cfg_tc_ie;
          cnt    <= cfg_size;
          err_q  <= !legal(cfg_dir, cfg_flow);
          en_q   <= cfg_en && legal(cfg_dir, cfg_flow);
          if (cfg_en && legal(cfg_dir, cfg_flow)) st <= S_REQ;
        end
        S_REQ:
          if (!en_q)                              st <= S_IDLE;
          else if (flow_q == FC_DMA && cnt == '0) st <= S_ACK;
          else if (pace_ok)                       st <= S_BEAT;
        S_BEAT: if (beat_done) begin
          if (flow_q == FC_DMA) cnt <= cnt - CNT_W'(1);
          if (!en_eff)       st <= S_IDLE;
          else if (last_hit) st <= S_ACK;
          else               st <= S_REQ;
        end
        S_ACK: st <= S_IRQ;
        S_IRQ: st <= S_NEXT;
        S_NEXT:
          if (next_lli == '0) begin
            en_q <= 1'b0;
            st   <= S_IDLE;
          end else st <= S_WLOAD;
        S_WLOAD:
          if (!en_q) st <= S_IDLE;
          else if (lli_reload) begin
            cnt <= cfg_size;
            st  <= S_REQ;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign beat_req = (st == S_BEAT);
  assign src_ack  = (st == S_ACK) && src_per;
  assign dst_ack  = (st == S_ACK) && dst_per;
  assign lli_load = (st == S_NEXT) && (next_lli != '0);
  assign tc_irq   = tc_q;
  assign ch_en    = en_q;
  assign cfg_err  = err_q;
  assign busy     = (st != S_IDLE);

  a_r3_illegal_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !busy && !legal(cfg_dir, cfg_flow)) |=> (cfg_err && !ch_en));

  a_r4_p2p_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(beat_req) && dir_q == P2P) |-> $past(src_req && dst_req));

  a_r5_no_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_req && beat_done && flow_q == FC_DMA) |-> (cnt != '0));

  a_r8_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ack || dst_ack) |=> !(src_ack || dst_ack));

  a_r8_irq_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && ie_q) |=> tc_irq);

  a_r8_load_not_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ack || dst_ack) |=> !lli_load);

  a_r10_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    lli_load |=> !lli_load);

  a_r11_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_req && beat_done && !en_q) |=> !(src_ack || dst_ack || lli_load));

endmodule

// File: tb/dma_flow_seq_test.sv
module dma_flow_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_en = 0, cfg_tc_ie = 0;
  logic [1:0] cfg_dir = 0;
  logic [2:0] cfg_flow = 0;
  logic [11:0] cfg_size = 0;
  logic src_req = 0, dst_req = 0, beat_done = 0, src_last = 0, dst_last = 0;
  logic tc_clr = 0, lli_reload = 0;
  logic [31:0] next_lli = 0;
  logic beat_req, src_ack, dst_ack, tc_irq, lli_load, ch_en, cfg_err, busy;

  dma_flow_seq uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int beats = 0, resp_limit = 1000, src_last_at = 0, dst_last_at = 0;
  int srca_n = 0, dsta_n = 0, load_n = 0, ack_cyc = 0, tc_cyc = 0, load_cyc = 0;
  logic tc_prev = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (beat_done) begin
      beat_done = 0; src_last = 0; dst_last = 0;
    end else if (beat_req && beats < resp_limit) begin
      beats++;
      beat_done = 1;
      src_last = (beats == src_last_at);
      dst_last = (beats == dst_last_at);
    end
  end

  always @(negedge clk) begin
    if (src_ack) srca_n++;
    if (dst_ack) dsta_n++;
    if (src_ack || dst_ack) ack_cyc = cyc;
    if (tc_irq && !tc_prev) tc_cyc = cyc;
    if (lli_load) begin load_n++; load_cyc = cyc; end
    tc_prev = tc_irq;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    beats = 0; srca_n = 0; dsta_n = 0; load_n = 0;
    resp_limit = 1000; src_last_at = 0; dst_last_at = 0;
  endtask

  task automatic write_cfg(input int d, input int f, input int sz, input bit ie, input bit en);
    @(negedge clk);
    cfg_dir = 2'(d); cfg_flow = 3'(f); cfg_size = 12'(sz); cfg_tc_ie = ie; cfg_en = en;
    cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_tc_clr();
    @(negedge clk); tc_clr = 1;
    @(negedge clk); tc_clr = 0;
  endtask

  task automatic t_reset();
    chk(!busy && !ch_en && !beat_req, "R1 idle after reset", busy, 0);
    chk(!src_ack && !dst_ack && !lli_load && !tc_irq && !cfg_err, "R1 outputs low", tc_irq, 0);
  endtask

  task automatic t_illegal();
    write_cfg(2, 1, 4, 1, 1); @(negedge clk);
    chk(cfg_err && !ch_en && !busy, "R3 m2m with source flow", cfg_err, 1);
    write_cfg(0, 1, 4, 1, 1); @(negedge clk);
    chk(cfg_err && !ch_en, "R3 m2p with source flow", cfg_err, 1);
    write_cfg(1, 2, 4, 1, 1); @(negedge clk);
    chk(cfg_err && !ch_en, "R3 p2m with destination flow", cfg_err, 1);
    write_cfg(3, 5, 4, 1, 1); @(negedge clk);
    chk(cfg_err && !ch_en, "R3 code 5", cfg_err, 1);
    write_cfg(2, 0, 0, 0, 0); @(negedge clk);
    chk(!cfg_err && !ch_en, "R3 legal write clears error", cfg_err, 0);
  endtask

  task automatic t_dma_count();
    clear_counts(); pulse_tc_clr(); next_lli = 0;
    write_cfg(2, 0, 3, 1, 1);
    chk(ch_en && busy, "R2 start on enabled write", ch_en, 1);
    wait_idle();
    chk(beats == 3, "R5 m2m beat count", beats, 3);
    chk(srca_n == 0 && dsta_n == 0, "R8 m2m no acks", srca_n + dsta_n, 0);
    chk(tc_irq && !ch_en && load_n == 0, "R10 zero next item disables", ch_en, 0);
  endtask

  task automatic t_pacing();
    clear_counts(); next_lli = 0; dst_req = 0; src_req = 0;
    write_cfg(0, 0, 2, 0, 1);
    repeat (10) @(negedge clk);
    chk(beats == 0 && busy, "R4 m2p waits for dst_req", beats, 0);
    dst_req = 1; wait_idle();
    chk(beats == 2 && !busy, "R4 m2p runs on dst_req", beats, 2);
    clear_counts(); dst_req = 0; src_req = 1;
    write_cfg(3, 0, 2, 0, 1);
    repeat (10) @(negedge clk);
    chk(beats == 0 && busy, "R4 p2p needs both requests", beats, 0);
    dst_req = 1; wait_idle();
    chk(beats == 2 && srca_n == 1 && dsta_n == 1, "R4 p2p runs with both", beats, 2);
  endtask

  task automatic t_zero();
    clear_counts(); pulse_tc_clr(); dst_req = 0; src_req = 0; next_lli = 0;
    write_cfg(0, 0, 0, 1, 1);
    wait_idle();
    chk(beats == 0, "R6 zero size no beats", beats, 0);
    chk(dsta_n == 1 && srca_n == 0 && tc_irq, "R6 zero size completes", dsta_n, 1);
  endtask

  task automatic t_perflow();
    clear_counts(); pulse_tc_clr(); src_req = 1; dst_req = 1; next_lli = 0;
    src_last_at = 5; dst_last_at = 2;
    write_cfg(1, 1, 2, 0, 1);
    wait_idle();
    chk(beats == 5, "R7 source flow ignores size and dst_last", beats, 5);
    chk(srca_n == 1 && dsta_n == 0, "R8 p2m acks source", srca_n, 1);
    chk(!tc_irq, "R9 no flag with interrupt disabled", tc_irq, 0);
    clear_counts(); src_last_at = 2; dst_last_at = 4;
    write_cfg(3, 2, 1, 1, 1);
    wait_idle();
    chk(beats == 4, "R7 destination flow ignores src_last", beats, 4);
    chk(tc_irq, "R9 flag with interrupt enabled", tc_irq, 1);
    repeat (3) @(negedge clk);
    chk(tc_irq, "R9 flag is sticky", tc_irq, 1);
    pulse_tc_clr();
    chk(!tc_irq, "R9 tc_clr clears flag", tc_irq, 0);
  endtask

  task automatic t_order_reload();
    clear_counts(); dst_req = 1; next_lli = 32'h100;
    write_cfg(0, 0, 1, 1, 1);
    for (int i = 0; i < 200 && load_n == 0; i++) @(negedge clk);
    chk(load_n == 1 && dsta_n == 1 && beats == 1, "R10 load request issued", load_n, 1);
    chk(tc_cyc == ack_cyc + 1, "R8 flag one cycle after ack", tc_cyc - ack_cyc, 1);
    chk(load_cyc == tc_cyc + 1, "R8 load one cycle after flag", load_cyc - tc_cyc, 1);
    repeat (3) @(negedge clk);
    chk(busy && ch_en && beats == 1, "R10 waits for reload", beats, 1);
    pulse_tc_clr();
    cfg_size = 12'd3; next_lli = 0;
    @(negedge clk); lli_reload = 1;
    @(negedge clk); lli_reload = 0;
    wait_idle();
    chk(beats == 4 && dsta_n == 2 && load_n == 1, "R10 reloaded packet", beats, 4);
    chk(!ch_en && tc_irq, "R10 end of chain disables", ch_en, 0);
  endtask

  task automatic t_abort();
    clear_counts(); pulse_tc_clr(); next_lli = 32'h200; resp_limit = 2;
    write_cfg(2, 0, 10, 1, 1);
    for (int i = 0; i < 200 && !(beats == 2 && beat_req); i++) @(negedge clk);
    write_cfg(2, 0, 10, 1, 0);
    resp_limit = 1000;
    wait_idle();
    chk(beats == 3, "R11 stops at beat boundary", beats, 3);
    chk(!tc_irq && load_n == 0 && srca_n + dsta_n == 0, "R11 no completion events", load_n, 0);
    chk(!ch_en, "R11 channel disabled", ch_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_illegal();
    t_dma_count();
    t_pacing();
    t_zero();
    t_perflow();
    t_order_reload();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule